// File: doc/BRIEF.md
# Isochronous Audio Frame Buffer

This block sits between the receiver of isochronous OUT packets and an audio output that pulls one sample per sample-clock request. Each 1 ms bus frame carries a variable number of PCM samples. The block writes them into one half of a two-half store. On every start-of-frame strobe the halves trade roles. The half that was just filled becomes the play-out half, and the other half is opened for the next packet. Output therefore always trails input by exactly one frame.

The number of samples written into a half is captured when the strobe closes it, and that count becomes the play-out length. When the output side asks for more samples than the frame held, the last sample is repeated and an underrun pulse is raised. Writes beyond the per-rate limit are dropped and raise an overrun pulse. Until a frame whose packet-end was seen has been closed, the output stays silent (zero). This also holds again after every change of the rate select.

Top module: `iso_audio_frame_buf`

## Requirements
- R1: After reset, `smp_data` is 0 and both `underrun` and `overrun` are 0.
- R2: While no complete frame has been closed since reset or since the last rate change, every request returns 0 and does not raise `underrun`.
- R3: Samples written between two strobes are returned in write order by the requests that follow the second strobe. The next frame's writes can take place meanwhile without disturbing them.
- R4: A closed frame yields exactly as many samples as were accepted into it. A request after that repeats the last sample returned and pulses `underrun` high together with the data.
- R5: With `rate_sel`=1 (48 kHz), a half accepts at most 49 samples. A write beyond that is dropped, and `overrun` is 1 in the cycle after that write.
- R6: With `rate_sel`=0 (44.1 kHz), a half accepts at most 45 samples. A write beyond that is dropped and pulses `overrun`.
- R7: A change of `rate_sel` discards the frame being received and returns the output to silence until a new complete frame is closed.
- R8: A frame closed without any write carrying `wr_last` does not end the silent state.
- R9: Without a request, `smp_data` holds its value and `underrun` is 0 one cycle later.
- R10: A write presented in the same cycle as `sof` is stored as the first sample of the newly opened half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 1 | 1 = 48 kHz, 0 = 44.1 kHz |
| sof | input | 1 | Start-of-frame strobe, one cycle |
| wr_valid | input | 1 | Sample write strobe |
| wr_data | input | SMP_W | Sample to write |
| wr_last | input | 1 | This write ends the frame's packet |
| smp_req | input | 1 | Output side asks for one sample |
| smp_data | output | SMP_W | Registered sample, valid the cycle after a request |
| underrun | output | 1 | Pulse: request found the frame exhausted |
| overrun | output | 1 | Pulse: a write exceeded the per-rate limit |

## Verification
On every cycle, the assertions check the following. The fill count never passes the limit for the current rate, and the read index never passes the latched frame length. Silence is produced while the output is unprimed. Flags pulse only in response to a write or a request, and idle cycles leave the output unchanged. Only the bench scenarios can show the properties that involve data. These are the one-frame delay and sample ordering, the exact per-frame length including the repeat value on underrun, the discard of a partial frame on a rate change, and the placement of a write that coincides with the strobe.

// File: rtl/iso_fb_pkg.sv
package iso_fb_pkg;
  typedef enum logic {
    RATE_44K1 = 1'b0,
    RATE_48K  = 1'b1
  } rate_e;
endpackage

// File: rtl/iso_fb_store.sv
module iso_fb_store #(
  parameter int SMP_W = 16,
  parameter int CAP   = 49,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic             w_half,
  input  logic [PTR_W-1:0] w_idx,
  input  logic [SMP_W-1:0] w_data,
  input  logic             r_half,
  input  logic [PTR_W-1:0] r_idx,
  output logic [SMP_W-1:0] r_data
);
  localparam int DEPTH = 2 * CAP;
  localparam int AW    = $clog2(DEPTH);

  logic [SMP_W-1:0] mem [DEPTH];
  logic [AW-1:0]    w_addr;
  logic [AW-1:0]    r_addr;
  logic [PTR_W-1:0] r_idx_c;

  always_comb begin
    r_idx_c = (r_idx >= PTR_W'(CAP)) ? PTR_W'(CAP - 1) : r_idx;
    w_addr  = AW'(w_idx) + (w_half ? AW'(CAP) : '0);
    r_addr  = AW'(r_idx_c) + (r_half ? AW'(CAP) : '0);
    r_data  = mem[r_addr];
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[w_addr] <= w_data;
    end
  end
endmodule

// File: rtl/iso_fb_wr.sv
module iso_fb_wr
  import iso_fb_pkg::*;
#(
  parameter int CAP    = 49,
  parameter int LIM_LO = 45,
  parameter int PTR_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  rate_e            rate,
  input  logic             rate_chg,
  input  logic             wr_valid,
  input  logic             wr_last,
  output logic             we,
  output logic             w_half,
  output logic [PTR_W-1:0] w_idx,
  output logic             half_q,
  output logic [PTR_W-1:0] fill_q,
  output logic             done_q,
  output logic             overrun
);
  logic             half_n;
  logic [PTR_W-1:0] fill_n;
  logic             done_n;
  logic             ovr_n;
  logic             ovr_q;
  logic [PTR_W-1:0] lim;
  logic [PTR_W-1:0] eff_ptr;
  logic             eff_done;
  logic             accept;

  always_comb begin
    lim      = (rate == RATE_48K) ? PTR_W'(CAP) : PTR_W'(LIM_LO);
    half_n   = sof ? ~half_q : half_q;
    eff_ptr  = sof ? '0 : fill_q;
    eff_done = sof ? 1'b0 : done_q;
    accept   = wr_valid && (eff_ptr < lim) && !rate_chg;
    ovr_n    = wr_valid && !accept && !rate_chg;
    fill_n   = eff_ptr + PTR_W'(accept);
    done_n   = eff_done | (wr_valid & wr_last & ~rate_chg);
    if (rate_chg) begin
      fill_n = '0;
      done_n = 1'b0;
    end
    we     = accept;
    w_half = half_n;
    w_idx  = eff_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      fill_q <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      half_q <= half_n;
      fill_q <= fill_n;
      done_q <= done_n;
      ovr_q  <= ovr_n;
    end
  end

  assign overrun = ovr_q;

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= PTR_W'(CAP));
  // R6
  lo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == RATE_44K1 && !rate_chg) |-> (fill_q <= PTR_W'(LIM_LO)));
  // R5
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(wr_valid));
  // R10
  sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (fill_q <= PTR_W'(1)));
endmodule

// File: rtl/iso_fb_rd.sv
module iso_fb_rd #(
  parameter int SMP_W = 16,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap,
  input  logic             rate_chg,
  input  logic [PTR_W-1:0] closed_len,
  input  logic             closed_done,
  input  logic             smp_req,
  input  logic [SMP_W-1:0] r_data,
  output logic [PTR_W-1:0] r_idx,
  output logic [SMP_W-1:0] smp_data,
  output logic             underrun
);
  logic             primed_q, primed_n;
  logic [PTR_W-1:0] len_q, len_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic [SMP_W-1:0] last_q, last_n;
  logic [SMP_W-1:0] out_q, out_n;
  logic             ur_q, ur_n;

  always_comb begin
    primed_n = primed_q;
    len_n    = len_q;
    ptr_n    = ptr_q;
    last_n   = last_q;
    out_n    = out_q;
    ur_n     = 1'b0;
    if (smp_req) begin
      if (!primed_q) begin
        out_n = '0;
      end else if (ptr_q < len_q) begin
        out_n  = r_data;
        last_n = r_data;
        ptr_n  = ptr_q + PTR_W'(1);
      end else begin
        out_n = last_q;
        ur_n  = 1'b1;
      end
    end
    if (swap) begin
      len_n    = closed_len;
      ptr_n    = '0;
      primed_n = primed_q | closed_done;
    end
    if (rate_chg) begin
      primed_n = 1'b0;
      len_n    = '0;
      ptr_n    = '0;
      last_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      len_q    <= '0;
      ptr_q    <= '0;
      last_q   <= '0;
      out_q    <= '0;
      ur_q     <= 1'b0;
    end else begin
      primed_q <= primed_n;
      len_q    <= len_n;
      ptr_q    <= ptr_n;
      last_q   <= last_n;
      out_q    <= out_n;
      ur_q     <= ur_n;
    end
  end

  assign r_idx    = ptr_q;
  assign smp_data = out_q;
  assign underrun = ur_q;

  // R4
  ptr_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= len_q);
  // R2
  silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req && !primed_q) |=> (smp_data == '0));
  // R4
  ur_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> ($past(smp_req) && $past(primed_q)));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_req |=> ($stable(smp_data) && !underrun));
endmodule

// File: rtl/iso_audio_frame_buf.sv
module iso_audio_frame_buf
  import iso_fb_pkg::*;
#(
  parameter int SMP_W      = 16,
  parameter int SPF_HI     = 48,
  parameter int SPF_LO_MAX = 45,
  parameter int JITTER     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_sel,
  input  logic             sof,
  input  logic             wr_valid,
  input  logic [SMP_W-1:0] wr_data,
  input  logic             wr_last,
  input  logic             smp_req,
  output logic [SMP_W-1:0] smp_data,
  output logic             underrun,
  output logic             overrun
);
  localparam int CAP   = SPF_HI + JITTER;
  localparam int PTR_W = $clog2(CAP + 1);

  rate_e            rate_cur;
  logic             rate_q;
  logic             rate_chg;
  logic             we;
  logic             w_half;
  logic [PTR_W-1:0] w_idx;
  logic             half_q;
  logic [PTR_W-1:0] fill_q;
  logic             done_q;
  logic [PTR_W-1:0] r_idx;
  logic [SMP_W-1:0] r_data;

  assign rate_cur = rate_e'(rate_sel);
  assign rate_chg = rate_sel ^ rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= 1'b0;
    else        rate_q <= rate_sel;
  end

  iso_fb_wr #(.CAP(CAP), .LIM_LO(SPF_LO_MAX), .PTR_W(PTR_W)) wr_i (
    .clk(clk), .rst_n(rst_n), .sof(sof), .rate(rate_cur), .rate_chg(rate_chg),
    .wr_valid(wr_valid), .wr_last(wr_last), .we(we), .w_half(w_half),
    .w_idx(w_idx), .half_q(half_q), .fill_q(fill_q), .done_q(done_q),
    .overrun(overrun)
  );

  iso_fb_store #(.SMP_W(SMP_W), .CAP(CAP), .PTR_W(PTR_W)) store_i (
    .clk(clk), .we(we), .w_half(w_half), .w_idx(w_idx), .w_data(wr_data),
    .r_half(~half_q), .r_idx(r_idx), .r_data(r_data)
  );

  iso_fb_rd #(.SMP_W(SMP_W), .PTR_W(PTR_W)) rd_i (
    .clk(clk), .rst_n(rst_n), .swap(sof), .rate_chg(rate_chg),
    .closed_len(fill_q), .closed_done(done_q), .smp_req(smp_req),
    .r_data(r_data), .r_idx(r_idx), .smp_data(smp_data), .underrun(underrun)
  );
endmodule

// File: tb/iso_audio_frame_buf_tb.sv
module iso_audio_frame_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rate_sel, sof, wr_valid, wr_last, smp_req;
  logic [SW-1:0] wr_data;
  logic [SW-1:0] smp_data;
  logic          underrun, overrun;
  int            n_checks = 0;
  int            n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  iso_audio_frame_buf dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .sof(sof),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
    .smp_req(smp_req), .smp_data(smp_data), .underrun(underrun),
    .overrun(overrun)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_sof();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  task automatic wr_frame(input int n, input int base, input bit last, input int lim);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) check((i - 1 >= lim) ? "R5/R6 overrun set" : "R5/R6 overrun clear",
                       int'(overrun), int'(i - 1 >= lim));
      wr_valid = 1'b1;
      wr_data  = SW'(base + i);
      wr_last  = last && (i == n - 1);
    end
    @(negedge clk);
    if (n > 0) check("R5/R6 overrun final", int'(overrun), int'(n - 1 >= lim));
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic req_check(input string tag, input int exp, input bit exp_ur);
    @(negedge clk); smp_req = 1'b1;
    @(negedge clk); smp_req = 1'b0;
    check({tag, " data"}, int'(smp_data), exp);
    check({tag, " underrun"}, int'(underrun), int'(exp_ur));
    @(negedge clk);
    check("R9 hold data", int'(smp_data), exp);
    check("R9 underrun idle", int'(underrun), 0);
  endtask

  task automatic read_frame(input int n, input int base);
    for (int i = 0; i < n; i++) req_check("R3/R4 play", base + i, 1'b0);
    req_check("R4 underrun repeat", base + n - 1, 1'b1);
  endtask

  task automatic sweep(input int lim, input int first_n, input int last_n, input int seed);
    int prev_n;
    int prev_base;
    prev_n = lim - 1;
    prev_base = seed;
    wr_frame(prev_n, prev_base, 1'b1, lim);
    pulse_sof();
    for (int n = first_n; n <= last_n; n++) begin
      int base;
      base = seed + 16'h0100 * (n - first_n + 1);
      wr_frame(n, base, 1'b1, lim);
      read_frame((prev_n > lim) ? lim : prev_n, prev_base);
      pulse_sof();
      prev_n = n;
      prev_base = base;
    end
    read_frame((prev_n > lim) ? lim : prev_n, prev_base);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rate_sel = 1'b1; sof = 1'b0; wr_valid = 1'b0;
    wr_last = 1'b0; wr_data = '0; smp_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 data", int'(smp_data), 0);
    check("R1 underrun", int'(underrun), 0);
    check("R1 overrun", int'(overrun), 0);

    req_check("R2 silent", 0, 1'b0);
    wr_frame(10, 16'h0050, 1'b0, 49);
    pulse_sof();
    req_check("R8 no packet end", 0, 1'b0);

    sweep(49, 46, 52, 16'h1000);

    // R10: write in the strobe cycle
    @(negedge clk);
    sof = 1'b1; wr_valid = 1'b1; wr_data = 16'hABCD; wr_last = 1'b0;
    @(negedge clk);
    sof = 1'b0; wr_valid = 1'b0;
    wr_frame(2, 16'hAB00, 1'b1, 48);
    pulse_sof();
    req_check("R10 first", 16'hABCD, 1'b0);
    req_check("R10 second", 16'hAB00, 1'b0);
    req_check("R10 third", 16'hAB01, 1'b0);
    req_check("R10 underrun", 16'hAB01, 1'b1);

    // R7: rate change discards partial receive and silences
    wr_frame(5, 16'h0700, 1'b1, 49);
    @(negedge clk); rate_sel = 1'b0;
    @(negedge clk);
    pulse_sof();
    req_check("R7 silent after change", 0, 1'b0);

    sweep(45, 42, 47, 16'h2000);

    @(negedge clk); rate_sel = 1'b1;
    @(negedge clk);
    req_check("R7 silent after return", 0, 1'b0);
    sweep(49, 48, 49, 16'h3000);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule